// File: doc/BRIEF.md
# Slow-Control Register File with Access Strobes

This block is the register front end of a board's slow-control agent. It sits on a simple internal bus with an address, a write data word and single-cycle read and write requests. It answers each request one clock later with either an acknowledge or an unknown-address response, and with read data when the request was a read.

The low 256 addresses hold four groups of 32-bit registers:
- Two common status words are fed by surrounding logic.
- One common control word carries board reset, reboot and dummy-trigger requests.
- A bank of user status registers is driven by logic and read over the bus.
- A bank of user control registers is written over the bus and drives logic.

The two user banks are sized by log2 parameters. Each bank stays inside its own fixed 64-address window.

Every read of a status register and every write of a control register raises a one-cycle strobe for that register. Logic can use the strobe to clear a counter on read or to act on a fresh setting. User control registers start from slices of a 2048-bit initial-value parameter. That parameter always holds 64 words, whatever bank size is configured.

Top module: `sc_regfile`

## Requirements
- R1: After reset, the following are all zero: bus_ack, bus_unk, bus_rdata, every strobe output and cctrl_out. User control register i holds bits [32*i+31:32*i] of CTRL_INIT.
- R2: A read of address 0x00 returns cstat0_in. A read of 0x01 returns tim_cnt_in in bits 31:16 and trg_cnt_in in bits 15:0. The read pulses cstat_strb[0] or cstat_strb[1] respectively.
- R3: A read of address 0x80+i, for i below 2^STAT_LOG, returns word i of ustat_in and pulses ustat_strb[i].
- R4: A write to address 0xC0+i, for i below 2^CTRL_LOG, loads word i of uctrl_out and pulses uctrl_strb[i]. A read of that address returns the stored value and raises no strobe.
- R5: A write to address 0x20 pulses cctrl_strb. Within that write:
  - Bits 31:24 are stored and held on cctrl_out.
  - Bits 0, 1, 2, 15 and 23:16 appear on cctrl_out for exactly one cycle.
  - All other bits are dropped.

  A read of 0x20 returns only the held bits 31:24.
- R6: A request to an address below 0x100 that maps to no register gets bus_unk instead of bus_ack, with bus_rdata zero, no strobe and no state change. This covers gaps between windows, user slots at or above the configured count, and writes to 0x00, 0x01 or status slots.
- R7: A request to an address of 0x100 or above gets neither bus_ack nor bus_unk, and changes no state.
- R8: Each cycle with a request produces exactly one response cycle, in the following cycle. bus_ack and bus_unk are never high together, and neither is high after a cycle without a request.
- R9: When bus_rd and bus_wr are high together, the request is handled as a write only.
- R10: At most one strobe output bit is high in any cycle, and a strobe is only ever high together with bus_ack.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read request, one cycle per access |
| bus_wr | input | 1 | Write request, one cycle per access |
| bus_addr | input | 16 | Register address |
| bus_wdata | input | 32 | Write data |
| cstat0_in | input | 32 | Value of common status word 0 |
| trg_cnt_in | input | 16 | Trigger-message count for common status word 1 |
| tim_cnt_in | input | 16 | Timing-trigger count for common status word 1 |
| ustat_in | input | 32*2^STAT_LOG | User status words, word i in bits [32*i+31:32*i] |
| bus_rdata | output | 32 | Read data, valid with bus_ack, else zero |
| bus_ack | output | 1 | Access completed |
| bus_unk | output | 1 | Unknown or read-only address inside the block |
| cctrl_out | output | 32 | Common control word: held bits plus request pulses |
| uctrl_out | output | 32*2^CTRL_LOG | User control words |
| cstat_strb | output | 2 | Read strobes for common status words 0 and 1 |
| cctrl_strb | output | 1 | Write strobe for the common control word |
| ustat_strb | output | 2^STAT_LOG | Read strobes for user status words |
| uctrl_strb | output | 2^CTRL_LOG | Write strobes for user control words |

## Verification
A decode fault shows up one cycle after the request in three ways: the wrong response kind, a strobe on the wrong bit, or data from the wrong word. A wrong stored control value does not show until the word is read back or observed on uctrl_out or cctrl_out, and it persists from then on. A pulse bit in the common control word that fails to clear is visible in the very next cycle. The bench therefore compares every output after every access, including idle cycles, against a bench model.

// File: rtl/sc_regs_pkg.sv
package sc_regs_pkg;

    localparam int DW = 32;
    localparam int AW = 16;
    localparam int MAX_REGS = 64;

    // Bits of the common control word that are one-cycle requests
    localparam logic [DW-1:0] CC_PULSE_MASK = 32'h00FF_8007;
    // Bits of the common control word that are stored
    localparam logic [DW-1:0] CC_HOLD_MASK  = 32'hFF00_0000;

    typedef enum logic [2:0] {
        RK_NONE,   // outside the block
        RK_CSTAT,  // common status
        RK_CCTRL,  // common control
        RK_USTAT,  // user status
        RK_UCTRL,  // user control
        RK_UNK     // inside the block, nothing implemented
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e   kind;
        logic [5:0]  idx;
    } reg_sel_t;

    function automatic logic [DW*MAX_REGS-1:0] default_ctrl_init();
        logic [DW*MAX_REGS-1:0] v;
        for (int i = 0; i < MAX_REGS; i++) begin
            v[DW*i +: DW] = 32'hC0DE_0000 | DW'(i);
        end
        return v;
    endfunction

    function automatic reg_sel_t decode_addr(logic [AW-1:0] a, int n_stat, int n_ctrl);
        reg_sel_t s;
        s.idx  = a[5:0];
        s.kind = RK_UNK;
        if (a[AW-1:8] != '0) begin
            s.kind = RK_NONE;
        end else if (a[7:1] == 7'h00) begin
            s.kind = RK_CSTAT;
        end else if (a[7:0] == 8'h20) begin
            s.kind = RK_CCTRL;
        end else if (a[7:6] == 2'b10) begin
            s.kind = (int'(a[5:0]) < n_stat) ? RK_USTAT : RK_UNK;
        end else if (a[7:6] == 2'b11) begin
            s.kind = (int'(a[5:0]) < n_ctrl) ? RK_UCTRL : RK_UNK;
        end
        return s;
    endfunction

endpackage

// File: rtl/sc_addr_decode.sv
module sc_addr_decode
    import sc_regs_pkg::*;
#(
    parameter int STAT_LOG = 2,
    parameter int CTRL_LOG = 2
) (
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    output reg_sel_t      sel,
    output logic          rd_hit,
    output logic          wr_hit,
    output logic          bad_hit
);
    localparam int N_STAT = 1 << STAT_LOG;
    localparam int N_CTRL = 1 << CTRL_LOG;

    logic req;
    logic read_only;

    always_comb begin
        sel       = decode_addr(bus_addr, N_STAT, N_CTRL);
        req       = (bus_rd | bus_wr) && (sel.kind != RK_NONE);
        read_only = (sel.kind == RK_CSTAT) || (sel.kind == RK_USTAT);
        // write takes precedence over a simultaneous read
        bad_hit   = req && ((sel.kind == RK_UNK) || (bus_wr && read_only));
        wr_hit    = req && !bad_hit && bus_wr;
        rd_hit    = req && !bad_hit && !bus_wr;
    end
endmodule

// File: rtl/sc_ctrl_bank.sv
module sc_ctrl_bank
    import sc_regs_pkg::*;
#(
    parameter int                    CTRL_LOG  = 2,
    parameter logic [DW*MAX_REGS-1:0] CTRL_INIT = default_ctrl_init()
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_hit,
    input  reg_sel_t                    sel,
    input  logic [DW-1:0]               wdata,
    output logic [DW*(1<<CTRL_LOG)-1:0] uctrl_q,
    output logic [(1<<CTRL_LOG)-1:0]    uctrl_strb,
    output logic [DW-1:0]               cc_held,
    output logic [DW-1:0]               cctrl_out,
    output logic                        cctrl_strb
);
    localparam int N_CTRL = 1 << CTRL_LOG;

    logic [DW-1:0] cc_pulse;

    for (genvar g = 0; g < N_CTRL; g++) begin : g_ureg
        logic hit;
        assign hit = wr_hit && (sel.kind == RK_UCTRL) && (sel.idx == 6'(g));
        always_ff @(posedge clk) begin
            if (rst) begin
                uctrl_q[DW*g +: DW] <= CTRL_INIT[DW*g +: DW];
                uctrl_strb[g]       <= 1'b0;
            end else begin
                if (hit) uctrl_q[DW*g +: DW] <= wdata;
                uctrl_strb[g] <= hit;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cc_held    <= '0;
            cc_pulse   <= '0;
            cctrl_strb <= 1'b0;
        end else begin
            cctrl_strb <= wr_hit && (sel.kind == RK_CCTRL);
            if (wr_hit && (sel.kind == RK_CCTRL)) begin
                cc_held  <= wdata & CC_HOLD_MASK;
                cc_pulse <= wdata & CC_PULSE_MASK;
            end else begin
                cc_pulse <= '0;
            end
        end
    end

    assign cctrl_out = cc_held | cc_pulse;
endmodule

// File: rtl/sc_read_path.sv
module sc_read_path
    import sc_regs_pkg::*;
#(
    parameter int STAT_LOG = 2,
    parameter int CTRL_LOG = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        rd_hit,
    input  logic                        wr_hit,
    input  logic                        bad_hit,
    input  reg_sel_t                    sel,
    input  logic [DW-1:0]               cstat0_in,
    input  logic [15:0]                 trg_cnt_in,
    input  logic [15:0]                 tim_cnt_in,
    input  logic [DW*(1<<STAT_LOG)-1:0] ustat_in,
    input  logic [DW*(1<<CTRL_LOG)-1:0] uctrl_q,
    input  logic [DW-1:0]               cc_held,
    output logic [DW-1:0]               bus_rdata,
    output logic                        bus_ack,
    output logic                        bus_unk,
    output logic [1:0]                  cstat_strb,
    output logic [(1<<STAT_LOG)-1:0]    ustat_strb
);
    localparam int N_STAT = 1 << STAT_LOG;
    localparam int N_CTRL = 1 << CTRL_LOG;

    logic [DW-1:0] rd_val;

    always_comb begin
        rd_val = '0;
        unique case (sel.kind)
            RK_CSTAT: rd_val = sel.idx[0] ? {tim_cnt_in, trg_cnt_in} : cstat0_in;
            RK_CCTRL: rd_val = cc_held;
            RK_USTAT: for (int i = 0; i < N_STAT; i++)
                          if (sel.idx == 6'(i)) rd_val = ustat_in[DW*i +: DW];
            RK_UCTRL: for (int i = 0; i < N_CTRL; i++)
                          if (sel.idx == 6'(i)) rd_val = uctrl_q[DW*i +: DW];
            default:  rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            bus_ack    <= 1'b0;
            bus_unk    <= 1'b0;
            cstat_strb <= '0;
            ustat_strb <= '0;
        end else begin
            bus_rdata <= rd_hit ? rd_val : '0;
            bus_ack   <= rd_hit | wr_hit;
            bus_unk   <= bad_hit;
            for (int i = 0; i < 2; i++)
                cstat_strb[i] <= rd_hit && (sel.kind == RK_CSTAT) && (sel.idx[0] == 1'(i));
            for (int i = 0; i < N_STAT; i++)
                ustat_strb[i] <= rd_hit && (sel.kind == RK_USTAT) && (sel.idx == 6'(i));
        end
    end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
    import sc_regs_pkg::*;
#(
    parameter int                     STAT_LOG  = 2,
    parameter int                     CTRL_LOG  = 2,
    parameter logic [DW*MAX_REGS-1:0] CTRL_INIT = default_ctrl_init()
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bus_rd,
    input  logic                        bus_wr,
    input  logic [15:0]                 bus_addr,
    input  logic [31:0]                 bus_wdata,
    input  logic [31:0]                 cstat0_in,
    input  logic [15:0]                 trg_cnt_in,
    input  logic [15:0]                 tim_cnt_in,
    input  logic [32*(1<<STAT_LOG)-1:0] ustat_in,
    output logic [31:0]                 bus_rdata,
    output logic                        bus_ack,
    output logic                        bus_unk,
    output logic [31:0]                 cctrl_out,
    output logic [32*(1<<CTRL_LOG)-1:0] uctrl_out,
    output logic [1:0]                  cstat_strb,
    output logic                        cctrl_strb,
    output logic [(1<<STAT_LOG)-1:0]    ustat_strb,
    output logic [(1<<CTRL_LOG)-1:0]    uctrl_strb
);
    reg_sel_t      sel;
    logic          rd_hit, wr_hit, bad_hit;
    logic [DW-1:0] cc_held;

    sc_addr_decode #(.STAT_LOG(STAT_LOG), .CTRL_LOG(CTRL_LOG)) u_dec (
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .sel(sel), .rd_hit(rd_hit), .wr_hit(wr_hit), .bad_hit(bad_hit)
    );

    sc_ctrl_bank #(.CTRL_LOG(CTRL_LOG), .CTRL_INIT(CTRL_INIT)) u_ctrl (
        .clk(clk), .rst(rst), .wr_hit(wr_hit), .sel(sel), .wdata(bus_wdata),
        .uctrl_q(uctrl_out), .uctrl_strb(uctrl_strb), .cc_held(cc_held),
        .cctrl_out(cctrl_out), .cctrl_strb(cctrl_strb)
    );

    sc_read_path #(.STAT_LOG(STAT_LOG), .CTRL_LOG(CTRL_LOG)) u_rd (
        .clk(clk), .rst(rst), .rd_hit(rd_hit), .wr_hit(wr_hit), .bad_hit(bad_hit),
        .sel(sel), .cstat0_in(cstat0_in), .trg_cnt_in(trg_cnt_in),
        .tim_cnt_in(tim_cnt_in), .ustat_in(ustat_in), .uctrl_q(uctrl_out),
        .cc_held(cc_held), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .bus_unk(bus_unk), .cstat_strb(cstat_strb), .ustat_strb(ustat_strb)
    );
endmodule

// File: rtl/sc_regfile_chk.sv
module sc_regfile_chk
    import sc_regs_pkg::*;
#(
    parameter int STAT_LOG = 2,
    parameter int CTRL_LOG = 2
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     bus_rd,
    input logic                     bus_wr,
    input logic [15:0]              bus_addr,
    input logic                     bus_ack,
    input logic                     bus_unk,
    input logic [31:0]              bus_rdata,
    input logic [31:0]              cctrl_out,
    input logic [1:0]               cstat_strb,
    input logic                     cctrl_strb,
    input logic [(1<<STAT_LOG)-1:0] ustat_strb,
    input logic [(1<<CTRL_LOG)-1:0] uctrl_strb
);
    logic [2+1+(1<<STAT_LOG)+(1<<CTRL_LOG)-1:0] all_strb;
    assign all_strb = {cstat_strb, cctrl_strb, ustat_strb, uctrl_strb};

    AST_ACK_UNK_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(bus_ack && bus_unk)); // R8
    AST_RESP_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd || bus_wr) |=> !(bus_ack || bus_unk)); // R8
    AST_FAR_ADDR_SILENT: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[15:8] != 8'h00) |=> !(bus_ack || bus_unk)); // R7
    AST_UNK_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        bus_unk |-> (bus_rdata == '0) && (all_strb == '0)); // R6
    AST_STRB_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(all_strb)); // R10
    AST_STRB_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
        (all_strb != '0) |-> bus_ack); // R10
    AST_PULSE_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        ((cctrl_out & CC_PULSE_MASK) != '0) |-> $past(bus_wr)); // R5
    AST_NO_RESERVED_BITS: assert property (@(posedge clk) disable iff (rst)
        (cctrl_out & ~(CC_PULSE_MASK | CC_HOLD_MASK)) == '0); // R5
endmodule

bind sc_regfile sc_regfile_chk #(.STAT_LOG(STAT_LOG), .CTRL_LOG(CTRL_LOG)) u_chk (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_ack(bus_ack), .bus_unk(bus_unk), .bus_rdata(bus_rdata),
    .cctrl_out(cctrl_out), .cstat_strb(cstat_strb), .cctrl_strb(cctrl_strb),
    .ustat_strb(ustat_strb), .uctrl_strb(uctrl_strb)
);

// File: tb/sim_sc_regfile.sv
module sim_sc_regfile;
    logic         clk = 1'b0;
    logic         rst;
    logic         bus_rd, bus_wr;
    logic [15:0]  bus_addr;
    logic [31:0]  bus_wdata, cstat0_in, bus_rdata, cctrl_out;
    logic [15:0]  trg_cnt_in, tim_cnt_in;
    logic [127:0] ustat_in, uctrl_out;
    logic         bus_ack, bus_unk, cctrl_strb;
    logic [1:0]   cstat_strb;
    logic [3:0]   ustat_strb, uctrl_strb;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] ctrl_m [4];
    logic [7:0]  hold_m;

    always #5 clk = ~clk;

    sc_regfile u0 (
        .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .cstat0_in(cstat0_in), .trg_cnt_in(trg_cnt_in),
        .tim_cnt_in(tim_cnt_in), .ustat_in(ustat_in), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .bus_unk(bus_unk), .cctrl_out(cctrl_out),
        .uctrl_out(uctrl_out), .cstat_strb(cstat_strb), .cctrl_strb(cctrl_strb),
        .ustat_strb(ustat_strb), .uctrl_strb(uctrl_strb)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    function automatic logic [31:0] init_word(int i);
        return 32'hC0DE_0000 + i;
    endfunction

    function automatic string tag_of(logic r, logic w, logic [15:0] a);
        if (r && w) return "R9";
        if (a >= 16'h100) return "R7";
        if (a <= 16'h1) return w ? "R6" : "R2";
        if (a == 16'h20) return "R5";
        if (a >= 16'h80 && a <= 16'hBF) return (a[5:0] < 4 && !w) ? "R3" : "R6";
        if (a >= 16'hC0) return (a[5:0] < 4) ? "R4" : "R6";
        return "R6";
    endfunction

    task automatic acc(input logic r, input logic w, input logic [15:0] a, input logic [31:0] d);
        logic        e_ack, e_unk;
        logic [31:0] e_dat, e_pulse;
        logic [10:0] e_str;
        int          i;
        string       t;
        t = tag_of(r, w, a);
        e_ack = 0; e_unk = 0; e_dat = 0; e_pulse = 0; e_str = 0;
        i = int'(a[5:0]);
        bus_rd = r; bus_wr = w; bus_addr = a; bus_wdata = d;
        if (r || w) begin
            if (a >= 16'h100) begin
                e_ack = 0;
            end else if (a <= 16'h1) begin
                if (w) e_unk = 1;
                else begin
                    e_ack = 1;
                    e_dat = a[0] ? {tim_cnt_in, trg_cnt_in} : cstat0_in;
                    e_str[9 + int'(a[0])] = 1;
                end
            end else if (a == 16'h20) begin
                e_ack = 1;
                if (w) begin
                    e_pulse = d & 32'h00FF_8007;
                    hold_m  = d[31:24];
                    e_str[8] = 1;
                end else e_dat = {hold_m, 24'h0};
            end else if (a >= 16'h80 && a <= 16'hBF) begin
                if (i < 4 && !w) begin
                    e_ack = 1; e_dat = ustat_in[32*i +: 32]; e_str[4+i] = 1;
                end else e_unk = 1;
            end else if (a >= 16'hC0) begin
                if (i < 4) begin
                    e_ack = 1;
                    if (w) begin ctrl_m[i] = d; e_str[i] = 1; end
                    else e_dat = ctrl_m[i];
                end else e_unk = 1;
            end else e_unk = 1;
        end
        @(negedge clk);
        check({t, " ack"},  32'(bus_ack), 32'(e_ack));
        check({t, " unk R8"}, 32'(bus_unk), 32'(e_unk));
        check({t, " rdata"}, bus_rdata, e_dat);
        check({t, " strobes R10"},
              32'({cstat_strb, cctrl_strb, ustat_strb, uctrl_strb}), 32'(e_str));
        check("R5 cctrl_out", cctrl_out, {hold_m, 24'h0} | e_pulse);
        for (int k = 0; k < 4; k++) check("R4 uctrl_out", uctrl_out[32*k +: 32], ctrl_m[k]);
        bus_rd = 0; bus_wr = 0;
    endtask

    function automatic logic [15:0] pick_addr(int k);
        case (k)
            0: return 16'h0000;  1: return 16'h0001;  2: return 16'h0020;
            3: return 16'h0080;  4: return 16'h0083;  5: return 16'h0084;
            6: return 16'h00BF;  7: return 16'h00C0;  8: return 16'h00C3;
            9: return 16'h00C4; 10: return 16'h00FF; 11: return 16'h0005;
           12: return 16'h007F; 13: return 16'h0100; 14: return 16'h01C1;
           15: return 16'h0081;
           default: return 16'h00C2;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        cstat0_in = 32'h1111_2222; trg_cnt_in = 16'h0033; tim_cnt_in = 16'h0044;
        ustat_in = {32'hD3D3_0003, 32'hD2D2_0002, 32'hD1D1_0001, 32'hD0D0_0000};
        hold_m = 0;
        for (int k = 0; k < 4; k++) ctrl_m[k] = init_word(k);
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1 ack", 32'(bus_ack), 0);
        check("R1 unk", 32'(bus_unk), 0);
        check("R1 rdata", bus_rdata, 0);
        check("R1 strobes", 32'({cstat_strb, cctrl_strb, ustat_strb, uctrl_strb}), 0);
        check("R1 cctrl_out", cctrl_out, 0);
        for (int k = 0; k < 4; k++) check("R1 uctrl init", uctrl_out[32*k +: 32], init_word(k));

        // directed corners
        acc(1, 0, 16'h0000, 0);             // R2
        acc(1, 0, 16'h0001, 0);             // R2
        acc(1, 0, 16'h0082, 0);             // R3
        acc(0, 1, 16'h00C1, 32'hCAFE_F00D); // R4
        acc(1, 0, 16'h00C1, 0);             // R4 read back, no strobe
        acc(0, 1, 16'h0020, 32'hAB12_F0FF); // R5 pulses and hold
        acc(0, 0, 16'h0020, 0);             // R5 pulse cleared, R8 idle quiet
        acc(1, 0, 16'h0020, 0);             // R5 read held bits only
        acc(0, 1, 16'h0000, 32'hFFFF_FFFF); // R6 write to read-only
        acc(0, 1, 16'h0085, 32'h1234_5678); // R6 write to status slot
        acc(0, 1, 16'h00C7, 32'h1234_5678); // R6 slot beyond count
        acc(1, 0, 16'h0040, 0);             // R6 gap
        acc(0, 1, 16'h01C0, 32'hDEAD_BEEF); // R7 no effect
        acc(1, 0, 16'h8000, 0);             // R7
        acc(1, 1, 16'h00C2, 32'h5555_AAAA); // R9 write wins
        acc(1, 0, 16'h00C2, 0);             // R9 value stored

        // constrained random
        for (int n = 0; n < 400; n++) begin
            int op;
            op = int'($urandom % 8);
            cstat0_in  = $urandom;
            trg_cnt_in = 16'($urandom);
            tim_cnt_in = 16'($urandom);
            ustat_in   = {$urandom, $urandom, $urandom, $urandom};
            acc(op < 4, (op >= 3 && op < 7), pick_addr(int'($urandom % 17)), $urandom);
        end
        finish_run();
    end
endmodule